// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This core completes one 32-bit instruction on every rising clock edge. The program counter drives the instruction port. In the same cycle, the word that comes back is decoded, both source registers are read, and a single ALU forms the result or the memory address. The register write, the optional data-memory write and the next program counter are then committed together at the next edge. The core runs a six-instruction integer subset: unsigned add, unsigned subtract, OR with an immediate, word load, word store and branch-if-equal.

The instruction memory and the data memory sit outside the core, on two independent ports. Each memory must return read data combinationally from its address and must write only on the clock edge while its write enable is high. Each cycle uses every piece of hardware at most once. For that reason the core has three separate adders: the PC incrementer, the branch-target adder and the ALU.

Top module: `onecycle_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0. `imem_addr` always shows the PC. Any instruction other than a taken branch makes the next PC equal to PC+4.
- R2: Opcode 0x00 with funct 0x21 writes R[rs]+R[rt] into R[rd], and funct 0x23 writes R[rs]-R[rt] into R[rd]. Both results wrap modulo 2^32. The fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: Opcode 0x0D writes R[rs] OR {16'h0, imm[15:0]} into R[rt]. The immediate is zero-extended.
- R4: Opcode 0x23 drives `dmem_addr` with R[rs] plus the sign-extended imm[15:0], holds `dmem_we` low, and writes `dmem_rdata` into R[rt].
- R5: Opcode 0x2B raises `dmem_we`, drives `dmem_addr` with R[rs] plus the sign-extended imm[15:0] and `dmem_wdata` with R[rt], and writes no register. `dmem_we` is low for every other instruction.
- R6: Opcode 0x04 sets the next PC to PC+4+(sign-extended imm[15:0] shifted left by 2) when R[rs] equals R[rt]. Otherwise the next PC is PC+4.
- R7: Register 0 always reads as zero. Writes that target it have no effect.
- R8: Any other encoding, including opcode 0x00 with a funct other than 0x21 or 0x23, changes no register and no memory and only advances the PC by 4.
- R9: An instruction reads its operands from the register values that held before its own write. A destination that is also a source therefore sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the PC |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word, returned combinationally for `imem_addr` |
| dmem_addr | output | 32 | Byte address for a load or a store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken by the data memory at the rising edge |
| dmem_rdata | input | 32 | Load data, returned combinationally for `dmem_addr` |

## Verification
Two things happen at the same edge: a register is read as an operand and the same register is written by that instruction. Which value the operand sees depends on how these two are ordered. Directed sequences such as `addu r1,r1,r1` followed by a store of r1 provoke this case, and so do random programs that often reuse a destination register as a source. The result is judged by a bench model that reads all operands before it commits any write. The model is compared, cycle by cycle, with the instruction address, the store strobe, the store address and the store data.

// File: rtl/onecycle_core.sv
module onecycle_core #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;
  localparam int         EXTW     = XLEN - 16;

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] rf [32];

  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd, rw;
  logic [15:0] imm;
  assign op  = imem_data[31:26];
  assign rs  = imem_data[25:21];
  assign rt  = imem_data[20:16];
  assign rd  = imem_data[15:11];
  assign fn  = imem_data[5:0];
  assign imm = imem_data[15:0];

  logic is_addu, is_subu, is_ori, is_lw, is_sw, is_beq, rf_we;
  assign is_addu = (op == OP_RTYPE) && (fn == FN_ADDU);
  assign is_subu = (op == OP_RTYPE) && (fn == FN_SUBU);
  assign is_ori  = (op == OP_ORI);
  assign is_lw   = (op == OP_LW);
  assign is_sw   = (op == OP_SW);
  assign is_beq  = (op == OP_BEQ);
  assign rf_we   = is_addu | is_subu | is_ori | is_lw;
  assign rw      = (is_addu | is_subu) ? rd : rt;

  logic [XLEN-1:0] bus_a, bus_b, imm_z, imm_s, opnd_b, alu_y, wb_data;
  assign bus_a  = (rs == 5'd0) ? '0 : rf[rs];
  assign bus_b  = (rt == 5'd0) ? '0 : rf[rt];
  assign imm_z  = {{EXTW{1'b0}}, imm};
  assign imm_s  = {{EXTW{imm[15]}}, imm};
  assign opnd_b = is_ori ? imm_z : (is_lw | is_sw) ? imm_s : bus_b;

  always_comb begin
    if (is_subu)     alu_y = bus_a - opnd_b;
    else if (is_ori) alu_y = bus_a | opnd_b;
    else             alu_y = bus_a + opnd_b;
  end

  assign wb_data = is_lw ? dmem_rdata : alu_y;

  logic [XLEN-1:0] pc_inc, br_off, br_tgt, pc_next;
  logic            take;
  assign pc_inc  = pc + XLEN'(4);
  assign br_off  = {imm_s[XLEN-3:0], 2'b00};
  assign br_tgt  = pc_inc + br_off;
  assign take    = is_beq && (bus_a == bus_b);
  assign pc_next = take ? br_tgt : pc_inc;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rf_we && (rw != 5'd0)) rf[rw] <= wb_data;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = bus_b;
  assign dmem_we    = is_sw;

  // R1
  rst_pc_chk: assert property (@(posedge clk) rst |=> imem_addr == '0);

  // R1
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    !is_beq |=> imem_addr == $past(imem_addr) + XLEN'(4));

  // R6
  br_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (is_beq && bus_a == bus_b) |=>
      imem_addr == $past(imem_addr) + XLEN'(4) + $past({imm_s[XLEN-3:0], 2'b00}));

  // R5
  st_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !rf_we);

  // R7
  r0_store_chk: assert property (@(posedge clk) disable iff (rst)
    (is_sw && rt == 5'd0) |-> dmem_wdata == '0);

  // R2
  wb_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we && rw != 5'd0) |=> rf[$past(rw)] == $past(wb_data));
endmodule

// File: tb/test_onecycle_core.sv
module test_onecycle_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem  [256];
  logic [31:0] dmem  [256];
  logic [31:0] mdmem [256];
  logic [31:0] mregs [32];
  logic [31:0] mpc;
  int nchk = 0, nbad = 0;
  string pc_tag = "R1";
  logic [4:0] prev_dest = 5'd0;
  logic       prev_self = 1'b0;

  always #4ns clk = ~clk;

  onecycle_core i_onecycle_core (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] o, int s, int t, logic [15:0] im);
    return {o, 5'(s), 5'(t), im};
  endfunction

  function automatic logic [31:0] sext(logic [15:0] im);
    return {{16{im[15]}}, im};
  endfunction

  function automatic logic [31:0] rand_instr();
    int k = $urandom_range(0, 7);
    int s = $urandom_range(0, 31);
    int t = $urandom_range(0, 31);
    int d = $urandom_range(0, 31);
    logic [15:0] im = 16'($urandom);
    case (k)
      0: return enc_r(s, t, d, 6'h21);
      1: return enc_r(s, t, d, 6'h23);
      2: return enc_i(6'h0D, s, t, im);
      3: return enc_i(6'h23, s, t, im);
      4: return enc_i(6'h2B, s, t, im);
      5: return enc_i(6'h2B, 0, t, 16'($urandom_range(0, 63) * 4));
      6: begin
        if ($urandom_range(0, 2) == 0) return enc_i(6'h04, s, s, 16'($urandom_range(0, 8)));
        return enc_i(6'h04, s, t, 16'($urandom_range(0, 16)) - 16'd8);
      end
      default: begin
        case ($urandom_range(0, 3))
          0: return enc_i(6'h3F, s, t, im);
          1: return enc_i(6'h08, s, t, im);
          2: return enc_r(s, t, d, 6'h20);
          default: return enc_r(s, t, d, 6'h25);
        endcase
      end
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h pc=%h", tag, act, exp, mpc);
    end
  endtask

  task automatic step();
    logic [31:0] ins = imem[mpc[9:2]];
    logic [5:0]  op = ins[31:26], fn = ins[5:0];
    logic [4:0]  s = ins[25:21], t = ins[20:16], d = ins[15:11];
    logic [31:0] a = mregs[s], b = mregs[t];
    logic [31:0] ea = a + sext(ins[15:0]);
    logic [4:0]  dest = 5'd0;
    logic [31:0] val = 32'd0;
    logic        wr = 1'b0;
    logic        hazard = prev_self && prev_dest != 5'd0 && (s == prev_dest || t == prev_dest);
    string       nt = "R1";
    chk(pc_tag, imem_addr, mpc);
    if (op == 6'h00 && (fn == 6'h21 || fn == 6'h23)) begin
      chk("R2", {31'd0, dmem_we}, 32'd0);
      wr = 1'b1; dest = d; val = (fn == 6'h21) ? a + b : a - b;
    end else if (op == 6'h0D) begin
      chk("R3", {31'd0, dmem_we}, 32'd0);
      wr = 1'b1; dest = t; val = a | {16'd0, ins[15:0]};
    end else if (op == 6'h23) begin
      chk(hazard ? "R9" : "R4", {31'd0, dmem_we}, 32'd0);
      chk(hazard ? "R9" : "R4", dmem_addr, ea);
      wr = 1'b1; dest = t; val = mdmem[ea[9:2]];
    end else if (op == 6'h2B) begin
      chk("R5", {31'd0, dmem_we}, 32'd1);
      chk(hazard ? "R9" : "R5", dmem_addr, ea);
      chk((t == 5'd0) ? "R7" : hazard ? "R9" : "R5", dmem_wdata, b);
      mdmem[ea[9:2]] = b;
    end else if (op == 6'h04) begin
      chk("R6", {31'd0, dmem_we}, 32'd0);
      nt = "R6";
    end else begin
      chk("R8", {31'd0, dmem_we}, 32'd0);
      nt = "R8";
    end
    prev_self = wr && (dest == s || (op == 6'h00 && dest == t));
    prev_dest = dest;
    if (wr && dest != 5'd0) mregs[dest] = val;
    if (op == 6'h04 && a == b) mpc = mpc + 32'd4 + {sext(ins[15:0])[29:0], 2'b00};
    else mpc = mpc + 32'd4;
    pc_tag = nt;
  endtask

  initial begin
    int p = 0;
    void'($urandom(32'd20515));
    for (int i = 0; i < 256; i++) begin
      dmem[i] = $urandom; mdmem[i] = dmem[i];
    end
    for (int i = 0; i < 32; i++) mregs[i] = 32'd0;
    for (int k = 1; k < 32; k++) begin
      imem[p] = enc_i(6'h0D, 0, k, 16'($urandom)); p++;
    end
    // R3 zero extension, R2 wrap, R7 r0 writes, R9 self update, R4 negative offset
    imem[p] = enc_i(6'h0D, 0, 1, 16'hFFFF); p++;
    imem[p] = enc_i(6'h2B, 0, 1, 16'd0);    p++;
    imem[p] = enc_r(0, 1, 3, 6'h23);        p++;
    imem[p] = enc_i(6'h2B, 0, 3, 16'd4);    p++;
    imem[p] = enc_r(1, 1, 2, 6'h21);        p++;
    imem[p] = enc_i(6'h0D, 0, 0, 16'h0055); p++;
    imem[p] = enc_i(6'h2B, 0, 0, 16'd8);    p++;
    imem[p] = enc_r(1, 1, 1, 6'h21);        p++;
    imem[p] = enc_i(6'h2B, 0, 1, 16'd12);   p++;
    imem[p] = enc_i(6'h0D, 0, 8, 16'd8);    p++;
    imem[p] = enc_i(6'h23, 8, 4, 16'hFFFC); p++;
    imem[p] = enc_i(6'h23, 4, 4, 16'd0);    p++;
    imem[p] = enc_i(6'h2B, 0, 4, 16'd16);   p++;
    // R6 taken skip and not taken, R8 undefined encodings
    imem[p] = enc_i(6'h04, 0, 0, 16'd1);    p++;
    imem[p] = enc_i(6'h0D, 0, 9, 16'h1234); p++;
    imem[p] = enc_i(6'h2B, 0, 9, 16'd20);   p++;
    imem[p] = enc_i(6'h04, 2, 0, 16'd5);    p++;
    imem[p] = 32'hFC00_0000;                p++;
    imem[p] = enc_r(2, 3, 5, 6'h20);        p++;
    imem[p] = enc_i(6'h2B, 0, 5, 16'd24);   p++;
    for (int i = p; i < 256; i++) imem[i] = rand_instr();

    mpc = 32'd0;
    repeat (3) @(negedge clk);
    chk("R1", imem_addr, 32'd0);
    rst = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      step();
      @(negedge clk);
    end
    rst = 1'b1;
    @(negedge clk);
    chk("R1", imem_addr, 32'd0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #(200000 * 8ns);
    nchk++; nbad++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule